// File: doc/BRIEF.md
# I2C Transmit/Receive Byte Queue with Ready Thresholds

This block sits between a host bus and the byte-level holding registers of an I2C controller. It holds two independent byte queues: one carries bytes the host writes toward the bus engine, the other carries bytes the engine receives back to the host. Each direction raises a ready flag once a programmable number of entries (one, two or four) is free (transmit) or stored (receive). The flags are meant to drive an interrupt line or a DMA request.

The host controls the block through a command word, where single bits flush either queue, switch queueing on or off, clear the transmit lock and reset the block. A mode word holds the two threshold selectors, and a level word reports both occupancies. Byte-wide host accesses work in both modes. Word-wide accesses move four bytes at once, least significant byte first. With queueing switched off, each direction behaves as a one-byte holding register. When the engine reports a not-acknowledge, the transmit side stops offering bytes until software clears the lock.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both queues are empty, queueing is off, the level word is zero, tx_ready is 1, rx_ready is 0, eng_tx_valid is 0 and all error flags and tx_locked are 0.
- R2: With queueing off, each direction holds at most one byte. One stored transmit byte drops tx_ready, and one stored receive byte raises rx_ready.
- R3: tx_ready is 1 when the free transmit entries reach the count selected by mode bits 1:0 (0 = one, 1 = two, 2 = four, 3 = four). This holds only while queueing is on; otherwise the count is one.
- R4: rx_ready is 1 when the stored receive entries reach the count selected by mode bits 5:4, with the same encoding as R3. This holds only while queueing is on; otherwise the count is one.
- R5: A word-wide host write pushes four bytes, bits 7:0 first and bits 31:24 last. The engine receives all transmit bytes in push order, one per cycle where eng_tx_valid and eng_tx_ready are both 1.
- R6: A host write that needs more entries than are free (four for word-wide, one for byte-wide) stores nothing and sets the sticky tx_overflow flag.
- R7: A byte-wide read returns the oldest receive byte in bits 7:0, with zeros above, and removes it. A word-wide read returns the four oldest bytes with the oldest in bits 7:0 and removes them, but only if four are stored. Otherwise nothing is removed and the sticky rx_underrun flag is set.
- R8: An engine receive byte that arrives with the receive queue full is dropped and sets the sticky rx_overrun flag.
- R9: Command bit 24 empties the transmit queue and bit 25 empties the receive queue. Bit 28 switches queueing on and bit 29 switches it off; if both are set, off wins. Either of these two bits empties both queues.
- R10: A pulse on eng_nack sets tx_locked, one cycle later. While tx_locked is set, eng_tx_valid stays 0 and no transmit byte leaves. Command bits 26 and 24 written together clear the lock and empty the transmit queue.
- R11: The level word carries the transmit count in bits 7:0 and the receive count in bits 23:16; all other bits are zero.
- R12: Command bit 7 empties both queues, switches queueing off, clears both threshold selectors, the lock and all three error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word strobe |
| cmd_word | input | 32 | Command bits (7, 24, 25, 26, 28, 29) |
| mode_wr | input | 1 | Mode word strobe |
| mode_word | input | 32 | Threshold selectors (bits 1:0 transmit, 5:4 receive) |
| host_wr | input | 1 | Host transmit write strobe |
| host_wr_wide | input | 1 | 1 = four-byte write, 0 = one byte |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host receive read strobe |
| host_rd_wide | input | 1 | 1 = four-byte read, 0 = one byte |
| host_rdata | output | 32 | Host read data (valid in the strobe cycle) |
| tx_ready | output | 1 | Transmit threshold reached |
| rx_ready | output | 1 | Receive threshold reached |
| level_word | output | 32 | Occupancy of both queues |
| tx_overflow | output | 1 | Sticky rejected-write flag |
| rx_underrun | output | 1 | Sticky rejected-read flag |
| rx_overrun | output | 1 | Sticky dropped-receive flag |
| tx_locked | output | 1 | Transmit lock after not-acknowledge |
| eng_tx_valid | output | 1 | Byte offered to the engine |
| eng_tx_data | output | 8 | Offered byte |
| eng_tx_ready | input | 1 | Engine takes the offered byte |
| eng_rx_valid | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte |
| eng_nack | input | 1 | Engine not-acknowledge pulse |

## Verification
A scoreboard follows transmit bytes from host writes to the engine port and receive bytes from the engine port to host reads. Single-byte and four-byte traffic are mixed, so byte order within a word and order across words are both checked. Threshold behaviour is tested by filling each queue to one entry short of and exactly at each selectable count, which separates the three encodings and the free-versus-stored sense of the two flags. Full, empty and lock states are each met with a stimulus that should be refused, and the level word then confirms that nothing moved.

// File: rtl/twfifo_pkg.sv
package twfifo_pkg;
  // Command word bit positions
  localparam int CMD_SRST  = 7;
  localparam int CMD_TXCLR = 24;
  localparam int CMD_RXCLR = 25;
  localparam int CMD_LKCLR = 26;
  localparam int CMD_QON   = 28;
  localparam int CMD_QOFF  = 29;
  // Mode word field positions
  localparam int MODE_TX_LSB = 0;
  localparam int MODE_RX_LSB = 4;
  // Bytes per wide access
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    THR_ONE  = 2'd0,
    THR_TWO  = 2'd1,
    THR_FOUR = 2'd2,
    THR_RSVD = 2'd3
  } thr_sel_e;

  function automatic logic [2:0] thr_need(thr_sel_e sel);
    case (sel)
      THR_ONE: return 3'd1;
      THR_TWO: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/twfifo_store.sv
module twfifo_store
  import twfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic [CNT_W-1:0]     cap,
  input  logic [2:0]           push_n,
  input  logic [8*LANES-1:0]   push_bytes,
  input  logic [2:0]           pop_n,
  output logic [8*LANES-1:0]   peek,
  output logic [CNT_W-1:0]     count,
  output logic [CNT_W-1:0]     free
);
  logic [7:0]       mem_q [DEPTH];
  logic [7:0]       mem_d [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mem_d = mem_q;
    for (int i = 0; i < LANES; i++) begin
      if (3'(i) < push_n) begin
        mem_d[wr_ptr_q + PTR_W'(i)] = push_bytes[8*i +: 8];
      end
    end
  end

  always_comb begin
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      cnt_d    = '0;
    end else begin
      wr_ptr_d = wr_ptr_q + PTR_W'(push_n);
      rd_ptr_d = rd_ptr_q + PTR_W'(pop_n);
      cnt_d    = cnt_q + CNT_W'(push_n) - CNT_W'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign peek[8*g +: 8] = mem_q[rd_ptr_q + PTR_W'(g)];
  end

  assign count = cnt_q;
  assign free  = cap - cnt_q;

  // R6 R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(push_n) <= free);

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= cnt_q);

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0));
endmodule

// File: rtl/twfifo_ctrl.sv
module twfifo_ctrl
  import twfifo_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic     mode_wr,
  input  logic [31:0] mode_word,
  input  logic     eng_nack,
  input  logic     tx_ovf_evt,
  input  logic     rx_unf_evt,
  input  logic     rx_ovr_evt,
  output logic     fifo_en,
  output thr_sel_e tx_sel,
  output thr_sel_e rx_sel,
  output logic     tx_flush,
  output logic     rx_flush,
  output logic     locked,
  output logic     tx_ovf,
  output logic     rx_unf,
  output logic     rx_ovr
);
  logic     srst, qon, qoff, lkclr;
  logic     en_q, en_d, lock_q, lock_d;
  logic     ovf_q, ovf_d, unf_q, unf_d, ovr_q, ovr_d;
  thr_sel_e txs_q, txs_d, rxs_q, rxs_d;
  logic     unused_bits;

  assign unused_bits = ^{cmd_word[31:30], cmd_word[27], cmd_word[23:8],
                         cmd_word[6:0], mode_word[31:6], mode_word[3:2]};

  assign srst  = cmd_wr & cmd_word[CMD_SRST];
  assign qon   = cmd_wr & cmd_word[CMD_QON];
  assign qoff  = cmd_wr & cmd_word[CMD_QOFF];
  assign lkclr = cmd_wr & cmd_word[CMD_LKCLR];

  assign tx_flush = srst | qon | qoff | (cmd_wr & cmd_word[CMD_TXCLR]);
  assign rx_flush = srst | qon | qoff | (cmd_wr & cmd_word[CMD_RXCLR]);

  always_comb begin
    en_d   = en_q;
    txs_d  = txs_q;
    rxs_d  = rxs_q;
    lock_d = lock_q;
    ovf_d  = ovf_q | tx_ovf_evt;
    unf_d  = unf_q | rx_unf_evt;
    ovr_d  = ovr_q | rx_ovr_evt;
    if (srst) begin
      en_d   = 1'b0;
      txs_d  = THR_ONE;
      rxs_d  = THR_ONE;
      lock_d = 1'b0;
      ovf_d  = 1'b0;
      unf_d  = 1'b0;
      ovr_d  = 1'b0;
    end else begin
      if (qoff)      en_d = 1'b0;
      else if (qon)  en_d = 1'b1;
      if (mode_wr) begin
        txs_d = thr_sel_e'(mode_word[MODE_TX_LSB +: 2]);
        rxs_d = thr_sel_e'(mode_word[MODE_RX_LSB +: 2]);
      end
      if (eng_nack)   lock_d = 1'b1;
      else if (lkclr) lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      txs_q  <= THR_ONE;
      rxs_q  <= THR_ONE;
      lock_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      txs_q  <= txs_d;
      rxs_q  <= rxs_d;
      lock_q <= lock_d;
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
      ovr_q  <= ovr_d;
    end
  end

  assign fifo_en = en_q;
  assign tx_sel  = txs_q;
  assign rx_sel  = rxs_q;
  assign locked  = lock_q;
  assign tx_ovf  = ovf_q;
  assign rx_unf  = unf_q;
  assign rx_ovr  = ovr_q;

  // R12
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!en_q && !lock_q && !ovf_q && !unf_q && !ovr_q &&
              txs_q == THR_ONE && rxs_q == THR_ONE));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
  import twfifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_word,
  input  logic        mode_wr,
  input  logic [31:0] mode_word,
  input  logic        host_wr,
  input  logic        host_wr_wide,
  input  logic [31:0] host_wdata,
  input  logic        host_rd,
  input  logic        host_rd_wide,
  output logic [31:0] host_rdata,
  output logic        tx_ready,
  output logic        rx_ready,
  output logic [31:0] level_word,
  output logic        tx_overflow,
  output logic        rx_underrun,
  output logic        rx_overrun,
  output logic        tx_locked,
  output logic        eng_tx_valid,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_tx_ready,
  input  logic        eng_rx_valid,
  input  logic [7:0]  eng_rx_data,
  input  logic        eng_nack
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             fifo_en, tx_flush, rx_flush, locked;
  thr_sel_e         tx_sel, rx_sel;
  logic [CNT_W-1:0] cap, tx_count, tx_free, rx_count, rx_free;
  logic [CNT_W-1:0] tx_need, rx_need, wr_n, rd_n;
  logic [31:0]      tx_peek, rx_peek;
  logic [2:0]       tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic             tx_acc, rd_acc, rx_acc;
  logic             tx_ovf_evt, rx_unf_evt, rx_ovr_evt;
  logic             offer;

  twfifo_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .cmd_word   (cmd_word),
    .mode_wr    (mode_wr),
    .mode_word  (mode_word),
    .eng_nack   (eng_nack),
    .tx_ovf_evt (tx_ovf_evt),
    .rx_unf_evt (rx_unf_evt),
    .rx_ovr_evt (rx_ovr_evt),
    .fifo_en    (fifo_en),
    .tx_sel     (tx_sel),
    .rx_sel     (rx_sel),
    .tx_flush   (tx_flush),
    .rx_flush   (rx_flush),
    .locked     (locked),
    .tx_ovf     (tx_overflow),
    .rx_unf     (rx_underrun),
    .rx_ovr     (rx_overrun)
  );

  // Capacity: full depth when queueing is on, one holding entry otherwise
  assign cap = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);

  // Transmit side: host pushes, engine pops
  always_comb begin
    wr_n       = host_wr_wide ? CNT_W'(LANES) : CNT_W'(1);
    tx_acc     = host_wr && !tx_flush && (tx_free >= wr_n);
    tx_ovf_evt = host_wr && !tx_flush && !tx_acc;
    tx_push_n  = tx_acc ? (host_wr_wide ? 3'd4 : 3'd1) : 3'd0;
    offer      = !locked && (tx_count != '0);
    tx_pop_n   = (offer && eng_tx_ready && !tx_flush) ? 3'd1 : 3'd0;
  end

  // Receive side: engine pushes, host pops
  always_comb begin
    rx_acc     = eng_rx_valid && !rx_flush && (rx_free != '0);
    rx_ovr_evt = eng_rx_valid && !rx_flush && (rx_free == '0);
    rx_push_n  = rx_acc ? 3'd1 : 3'd0;
    rd_n       = host_rd_wide ? CNT_W'(LANES) : CNT_W'(1);
    rd_acc     = host_rd && !rx_flush && (rx_count >= rd_n);
    rx_unf_evt = host_rd && !rx_flush && !rd_acc;
    rx_pop_n   = rd_acc ? (host_rd_wide ? 3'd4 : 3'd1) : 3'd0;
  end

  twfifo_store #(.DEPTH(DEPTH)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (tx_flush),
    .cap        (cap),
    .push_n     (tx_push_n),
    .push_bytes (host_wdata),
    .pop_n      (tx_pop_n),
    .peek       (tx_peek),
    .count      (tx_count),
    .free       (tx_free)
  );

  twfifo_store #(.DEPTH(DEPTH)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (rx_flush),
    .cap        (cap),
    .push_n     (rx_push_n),
    .push_bytes ({24'h000000, eng_rx_data}),
    .pop_n      (rx_pop_n),
    .peek       (rx_peek),
    .count      (rx_count),
    .free       (rx_free)
  );

  // Threshold flags
  assign tx_need  = fifo_en ? CNT_W'(thr_need(tx_sel)) : CNT_W'(1);
  assign rx_need  = fifo_en ? CNT_W'(thr_need(rx_sel)) : CNT_W'(1);
  assign tx_ready = (tx_free >= tx_need);
  assign rx_ready = (rx_count >= rx_need);

  assign host_rdata   = host_rd_wide ? rx_peek : {24'h000000, rx_peek[7:0]};
  assign eng_tx_valid = offer;
  assign eng_tx_data  = tx_peek[7:0];
  assign tx_locked    = locked;
  assign level_word   = {8'h00, 8'(rx_count), 8'h00, 8'(tx_count)};

  // R2
  single_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> (tx_count <= CNT_W'(1) && rx_count <= CNT_W'(1)));

  // R10
  lock_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !tx_flush) |=> (tx_count >= $past(tx_count)));
endmodule

// File: tb/i2c_fifo_pair_tb.sv
`timescale 1ns/1ps
module i2c_fifo_pair_tb;
  logic        clk, rst_n;
  logic        cmd_wr, mode_wr, host_wr, host_wr_wide, host_rd, host_rd_wide;
  logic [31:0] cmd_word, mode_word, host_wdata, host_rdata, level_word;
  logic        tx_ready, rx_ready, tx_overflow, rx_underrun, rx_overrun, tx_locked;
  logic        eng_tx_valid, eng_tx_ready, eng_rx_valid, eng_nack;
  logic [7:0]  eng_tx_data, eng_rx_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_tx[$];
  logic [7:0] exp_rx[$];

  i2c_fifo_pair #(.DEPTH(16)) u_dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [31:0] d, input bit wide, input bit ok);
    @(posedge clk); #1;
    host_wr = 1'b1; host_wr_wide = wide; host_wdata = d;
    if (ok) for (int i = 0; i < (wide ? 4 : 1); i++) exp_tx.push_back(d[8*i +: 8]);
    @(posedge clk); #1;
    host_wr = 1'b0; host_wr_wide = 1'b0;
  endtask

  task automatic host_read(input bit wide, input bit ok);
    logic [31:0] e;
    @(posedge clk); #1;
    host_rd = 1'b1; host_rd_wide = wide;
    @(negedge clk);
    if (ok) begin
      e = '0;
      for (int i = 0; i < (wide ? 4 : 1); i++) e[8*i +: 8] = exp_rx.pop_front();
      check("R7 read data", host_rdata, e);
    end
    @(posedge clk); #1;
    host_rd = 1'b0; host_rd_wide = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b, input bit ok);
    @(posedge clk); #1;
    eng_rx_valid = 1'b1; eng_rx_data = b;
    if (ok) exp_rx.push_back(b);
    @(posedge clk); #1;
    eng_rx_valid = 1'b0;
  endtask

  task automatic send_cmd(input logic [31:0] w);
    @(posedge clk); #1; cmd_wr = 1'b1; cmd_word = w;
    @(posedge clk); #1; cmd_wr = 1'b0; cmd_word = '0;
  endtask

  task automatic send_mode(input logic [31:0] w);
    @(posedge clk); #1; mode_wr = 1'b1; mode_word = w;
    @(posedge clk); #1; mode_wr = 1'b0;
  endtask

  task automatic drain(input int n);
    @(posedge clk); #1; eng_tx_ready = 1'b1;
    repeat (n) @(posedge clk);
    #1; eng_tx_ready = 1'b0;
  endtask

  task automatic pulse_nack();
    @(posedge clk); #1; eng_nack = 1'b1;
    @(posedge clk); #1; eng_nack = 1'b0;
  endtask

  // Scoreboard monitor on the engine transmit port
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && eng_tx_valid && eng_tx_ready) begin
        if (exp_tx.size() == 0) check("R5 unexpected engine byte", {24'h0, eng_tx_data}, 32'hFFFF_FFFF);
        else check("R5 engine byte order", {24'h0, eng_tx_data}, {24'h0, exp_tx.pop_front()});
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 0; mode_wr = 0; host_wr = 0; host_wr_wide = 0; host_rd = 0;
    host_rd_wide = 0; cmd_word = '0; mode_word = '0; host_wdata = '0;
    eng_tx_ready = 0; eng_rx_valid = 0; eng_rx_data = '0; eng_nack = 0;
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;

    @(negedge clk);
    check("R1 level", level_word, 32'h0);
    check("R1 tx_ready", {31'h0, tx_ready}, 32'h1);
    check("R1 rx_ready", {31'h0, rx_ready}, 32'h0);
    check("R1 eng_tx_valid", {31'h0, eng_tx_valid}, 32'h0);
    check("R1 flags", {28'h0, tx_overflow, rx_underrun, rx_overrun, tx_locked}, 32'h0);

    // Queueing off: single holding entry per direction
    host_write(32'hA5, 0, 1);
    @(negedge clk);
    check("R2 tx single level", level_word, 32'h1);
    check("R2 tx_ready off when held", {31'h0, tx_ready}, 32'h0);
    host_write(32'h5A, 0, 0);
    @(negedge clk);
    check("R6 overflow flag", {31'h0, tx_overflow}, 32'h1);
    check("R6 level unchanged", level_word, 32'h1);
    drain(2);
    @(negedge clk);
    check("R2 tx drained", level_word, 32'h0);
    eng_push(8'h11, 1);
    @(negedge clk);
    check("R2 rx_ready single", {31'h0, rx_ready}, 32'h1);
    eng_push(8'h22, 0);
    @(negedge clk);
    check("R8 overrun when held", {31'h0, rx_overrun}, 32'h1);
    check("R2 rx single level", level_word, 32'h0001_0000);
    host_read(0, 1);
    send_cmd(32'h0000_0080);
    @(negedge clk);
    check("R12 flags cleared", {29'h0, tx_overflow, rx_underrun, rx_overrun}, 32'h0);
    check("R12 level cleared", level_word, 32'h0);

    // Queueing on, transmit thresholds
    send_cmd(32'h1000_0000);
    send_mode(32'h0000_0002);
    for (int i = 0; i < 13; i++) host_write(32'h10 + i, 0, 1);
    @(negedge clk);
    check("R3 four-free mode with 3 free", {31'h0, tx_ready}, 32'h0);
    send_mode(32'h0000_0001);
    @(negedge clk);
    check("R3 two-free mode with 3 free", {31'h0, tx_ready}, 32'h1);
    host_write(32'h1D, 0, 1);
    host_write(32'h1E, 0, 1);
    @(negedge clk);
    check("R3 two-free mode with 1 free", {31'h0, tx_ready}, 32'h0);
    send_mode(32'h0000_0000);
    @(negedge clk);
    check("R3 one-free mode with 1 free", {31'h0, tx_ready}, 32'h1);
    host_write(32'h1F, 0, 1);
    @(negedge clk);
    check("R3 full", {31'h0, tx_ready}, 32'h0);
    check("R11 tx level full", level_word, 32'h0000_0010);
    host_write(32'hDEADBEEF, 1, 0);
    @(negedge clk);
    check("R6 wide write rejected", {31'h0, tx_overflow}, 32'h1);
    check("R6 level after reject", level_word, 32'h0000_0010);
    drain(16);
    @(negedge clk);
    check("R5 tx emptied", level_word, 32'h0);
    check("R5 scoreboard empty", exp_tx.size(), 32'h0);

    // Wide writes
    host_write(32'h44332211, 1, 1);
    host_write(32'h88776655, 1, 1);
    @(negedge clk);
    check("R11 tx level 8", level_word, 32'h0000_0008);
    drain(8);
    @(negedge clk);
    check("R5 wide drained", exp_tx.size(), 32'h0);

    // Receive thresholds
    send_mode(32'h0000_0010);
    eng_push(8'hC1, 1);
    @(negedge clk);
    check("R4 two-stored mode with 1", {31'h0, rx_ready}, 32'h0);
    eng_push(8'hC2, 1);
    @(negedge clk);
    check("R4 two-stored mode with 2", {31'h0, rx_ready}, 32'h1);
    send_mode(32'h0000_0020);
    @(negedge clk);
    check("R4 four-stored mode with 2", {31'h0, rx_ready}, 32'h0);
    eng_push(8'hC3, 1);
    @(negedge clk);
    check("R4 four-stored mode with 3", {31'h0, rx_ready}, 32'h0);
    eng_push(8'hC4, 1);
    @(negedge clk);
    check("R4 four-stored mode with 4", {31'h0, rx_ready}, 32'h1);
    check("R11 rx level field", level_word, 32'h0004_0000);
    host_read(1, 1);
    @(negedge clk);
    check("R7 wide read pops four", level_word, 32'h0);
    eng_push(8'hD1, 1);
    host_read(1, 0);
    @(negedge clk);
    check("R7 underrun flag", {31'h0, rx_underrun}, 32'h1);
    check("R7 nothing removed", level_word, 32'h0001_0000);
    host_read(0, 1);

    // Receive overrun and flushes
    send_mode(32'h0);
    for (int i = 0; i < 16; i++) eng_push(8'hE0 + 8'(i), 1);
    eng_push(8'hFF, 0);
    @(negedge clk);
    check("R8 overrun flag", {31'h0, rx_overrun}, 32'h1);
    check("R8 level stays full", level_word, 32'h0010_0000);
    send_cmd(32'h0200_0000);
    exp_rx.delete();
    @(negedge clk);
    check("R9 rx flush", level_word, 32'h0);
    host_write(32'h31, 0, 1);
    host_write(32'h32, 0, 1);
    send_cmd(32'h0100_0000);
    exp_tx.delete();
    @(negedge clk);
    check("R9 tx flush", level_word, 32'h0);

    // Lock after not-acknowledge
    host_write(32'h41, 0, 1);
    host_write(32'h42, 0, 1);
    pulse_nack();
    @(negedge clk);
    check("R10 locked", {31'h0, tx_locked}, 32'h1);
    check("R10 nothing offered", {31'h0, eng_tx_valid}, 32'h0);
    drain(3);
    @(negedge clk);
    check("R10 level held while locked", level_word, 32'h0000_0002);
    send_cmd(32'h0500_0000);
    exp_tx.delete();
    @(negedge clk);
    check("R10 unlocked", {31'h0, tx_locked}, 32'h0);
    check("R10 flushed on unlock", level_word, 32'h0);
    host_write(32'h43, 0, 1);
    drain(1);
    @(negedge clk);
    check("R10 feeding resumes", exp_tx.size(), 32'h0);

    // Soft reset returns to single-entry mode
    send_mode(32'h0000_0022);
    send_cmd(32'h0000_0080);
    @(negedge clk);
    check("R12 flags cleared again", {29'h0, tx_overflow, rx_underrun, rx_overrun}, 32'h0);
    host_write(32'h55, 0, 1);
    @(negedge clk);
    check("R12 queueing off after reset", {31'h0, tx_ready}, 32'h0);
    drain(1);
    @(negedge clk);
    check("R12 drained", level_word, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule